// File: doc/BRIEF.md
# I2C Multi-Master Arbitration Monitor

This block sits beside the SDA driver of an I2C master and decides, one bit at a time, whether that master still owns a bus that several masters share. The bus is a wired-AND line. A master sends a 0 by pulling SDA low. It sends a 1 by letting the pull-up hold the line high. As a result, any master that drives a 0 overrides every master that sends a 1. Masters have no fixed priority. A master learns that it has lost only by reading back a level it did not send. The slave takes no part in this.

During a transfer, the surrounding clock logic pulses `sample_stb` once in each SCL high phase. On that strobe, the block compares the bit it is sending with the SDA level it reads back through a two-stage synchronizer. If it sent 1 and reads 0, another master has won. The block then raises a sticky loss flag and emits a single-cycle loss pulse. It also keeps its pull-low enable off until the transfer ends, so the winner finishes undisturbed. If it sent 0 and reads 1, the bus cannot be behaving as a wired-AND. The block reports this as a separate fault pulse and does not treat it as a loss. Bits that match need no action.

A state machine holds the ownership state. It has three states. ST_IDLE means no transfer is active. ST_OWN means a transfer is active and the block still drives. ST_LOST means a transfer is active and arbitration has been lost. There are five transitions:

- T_START goes from ST_IDLE to ST_OWN when the transfer starts.
- T_LOSE goes from ST_IDLE or ST_OWN to ST_LOST on a strobed 1-sent/0-read mismatch while the transfer is active.
- T_END goes from ST_OWN to ST_IDLE when the transfer stops.
- T_RELEASE goes from ST_LOST to ST_IDLE when the transfer stops.
- Reset forces ST_IDLE.

Top module: `arbmon_top`

## Requirements
- R1: After reset, `sda_pull_en`, `arb_lost`, `arb_lost_pulse` and `bus_fault_pulse` are all 0. The synchronizer starts at 1, which is the idle bus level.
- R2: `sda_pull_en` is 1 exactly when `xfer_active` is 1, `tx_bit` is 0 and `arb_lost` is 0. It follows these inputs in the same cycle, so sending a 1 always releases the line.
- R3: If `sample_stb` is 1 at a clock edge while `xfer_active` is 1, `arb_lost` is 0, `tx_bit` is 1 and the synchronized SDA is 0, then `arb_lost` reads 1 after that edge.
- R4: `arb_lost_pulse` is 1 for exactly one cycle. That cycle follows the edge at which the mismatch of R3 was sampled.
- R5: `arb_lost` stays 1 while `xfer_active` stays 1. While it is set, `sda_pull_en` is 0 whatever `tx_bit` is, and further strobes raise no pulse.
- R6: `arb_lost` reads 0 after the first clock edge at which `xfer_active` is 0.
- R7: A strobed compare with `tx_bit` 0 and synchronized SDA 1 raises `bus_fault_pulse` for one cycle after that edge. It does not set `arb_lost`.
- R8: A strobed compare where the sent bit equals the synchronized SDA level raises neither pulse and leaves `arb_lost` unchanged.
- R9: Without `sample_stb`, or with `xfer_active` 0, no SDA level causes a loss or a fault.
- R10: The compare uses SDA as sampled two clock edges earlier. An SDA change that occurs only one edge before the strobe edge is not yet seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_active | input | 1 | A transfer by this master is in progress |
| tx_bit | input | 1 | Bit this master is sending now |
| sda_in | input | 1 | Raw SDA level read from the pin |
| sample_stb | input | 1 | One-cycle strobe in the SCL high phase that requests a compare |
| sda_pull_en | output | 1 | Enable for the open-drain pull-low driver |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| arb_lost_pulse | output | 1 | One-cycle pulse marking the loss |
| bus_fault_pulse | output | 1 | One-cycle pulse for a 0-sent/1-read compare |

## Verification
Assertions check several rules on every cycle: the driver stays off while the loss flag is set, the loss pulse never lasts two cycles, and every loss pulse coincides with the flag being set. They also check that a fault pulse never accompanies a loss, that the flag holds while the transfer is active, and that it clears once the transfer stops. Other behaviour can only be shown by the bench's scenarios. This covers the exact cycle on which a strobed mismatch becomes visible, and the two-edge delay through the synchronizer. It also covers strobes outside a transfer or outside the strobe cycle being ignored, and the way matching bits, faults and losses combine over long random sequences.

// File: rtl/arbmon_pkg.sv
package arbmon_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,
        ST_LOST = 2'd2
    } arb_state_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/arbmon_sync.sv
module arbmon_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[LAST];

endmodule

// File: rtl/arbmon_fsm.sv
module arbmon_fsm
    import arbmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic tx_bit,
    input  logic sda_seen,
    input  logic sample_stb,
    output logic sda_pull_en,
    output logic arb_lost,
    output logic arb_lost_pulse,
    output logic bus_fault_pulse
);
    arb_state_e state_q, state_d;
    logic owning;
    logic lose_ev;
    logic fault_ev;

    // Compare events: only on the strobe, only while still driving.
    always_comb begin
        owning   = xfer_active && (state_q != ST_LOST);
        lose_ev  = owning && sample_stb &&  tx_bit && !sda_seen;
        fault_ev = owning && sample_stb && !tx_bit &&  sda_seen;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (lose_ev)          state_d = ST_LOST;   // T_LOSE
                else if (xfer_active) state_d = ST_OWN;    // T_START
            end
            ST_OWN: begin
                if (!xfer_active)     state_d = ST_IDLE;   // T_END
                else if (lose_ev)     state_d = ST_LOST;   // T_LOSE
            end
            ST_LOST: begin
                if (!xfer_active)     state_d = ST_IDLE;   // T_RELEASE
            end
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: event pulses.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_lost_pulse  <= 1'b0;
            bus_fault_pulse <= 1'b0;
        end else begin
            arb_lost_pulse  <= lose_ev;
            bus_fault_pulse <= fault_ev;
        end
    end

    // Level outputs.
    always_comb begin
        arb_lost    = (state_q == ST_LOST);
        sda_pull_en = owning && !tx_bit;
    end

    // R5
    pull_off_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_pull_en);

    // R4
    lost_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_pulse |=> !arb_lost_pulse);

    // R3
    lost_pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_pulse |-> arb_lost);

    // R5
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && xfer_active) |=> arb_lost);

    // R6
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !arb_lost);

    // R7
    fault_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault_pulse |-> !arb_lost_pulse);

    // R1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!arb_lost_pulse && !bus_fault_pulse);
        end
    end

endmodule

// File: rtl/arbmon_top.sv
module arbmon_top
    import arbmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic tx_bit,
    input  logic sda_in,
    input  logic sample_stb,
    output logic sda_pull_en,
    output logic arb_lost,
    output logic arb_lost_pulse,
    output logic bus_fault_pulse
);
    logic sda_seen;

    // R10: two-stage synchronizer, idle-high reset value (R1)
    arbmon_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sda_in),
        .q     (sda_seen)
    );

    arbmon_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .xfer_active     (xfer_active),
        .tx_bit          (tx_bit),
        .sda_seen        (sda_seen),
        .sample_stb      (sample_stb),
        .sda_pull_en     (sda_pull_en),
        .arb_lost        (arb_lost),
        .arb_lost_pulse  (arb_lost_pulse),
        .bus_fault_pulse (bus_fault_pulse)
    );

endmodule

// File: tb/arbmon_top_bench.sv
module arbmon_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 1234;
    localparam int N_RANDOM   = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_active = 1'b0;
    logic tx_bit = 1'b0;
    logic sda_in = 1'b1;
    logic sample_stb = 1'b0;
    logic sda_pull_en, arb_lost, arb_lost_pulse, bus_fault_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model state
    logic m_s1 = 1'b1, m_s2 = 1'b1, m_lost = 1'b0;
    logic m_lpulse = 1'b0, m_fpulse = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arbmon_top u_arbmon_top (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .tx_bit(tx_bit),
        .sda_in(sda_in), .sample_stb(sample_stb), .sda_pull_en(sda_pull_en),
        .arb_lost(arb_lost), .arb_lost_pulse(arb_lost_pulse),
        .bus_fault_pulse(bus_fault_pulse)
    );

    function automatic logic exp_pull(logic act, logic tx, logic lost);
        return act && !tx && !lost;
    endfunction

    task automatic check(string req, logic act_v, logic exp_v);
        n_checks++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act_v, exp_v, $time);
        end
    endtask

    // Drive inputs at a falling edge, check the same-cycle driver enable,
    // advance one rising edge, update the model, then check registered outputs.
    task automatic step(logic act, logic tx, logic sda, logic stb, string tag);
        logic own, lev, fev;
        xfer_active = act; tx_bit = tx; sda_in = sda; sample_stb = stb;
        #1;
        check({tag, " R2 pull_en"}, sda_pull_en, exp_pull(act, tx, m_lost));
        @(posedge clk);
        own = act && !m_lost;
        lev = own && stb &&  tx && !m_s2;
        fev = own && stb && !tx &&  m_s2;
        m_lost   = act ? (m_lost || lev) : 1'b0;
        m_lpulse = lev;
        m_fpulse = fev;
        m_s2 = m_s1;
        m_s1 = sda;
        @(negedge clk);
        check({tag, " R3/R5/R6 arb_lost"}, arb_lost, m_lost);
        check({tag, " R4 lost_pulse"}, arb_lost_pulse, m_lpulse);
        check({tag, " R7/R8 fault_pulse"}, bus_fault_pulse, m_fpulse);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        int unused_seed;
        unused_seed = $urandom(SEED);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pull_en",  sda_pull_en, 1'b0);
        check("R1 arb_lost", arb_lost, 1'b0);
        check("R1 lost_pulse", arb_lost_pulse, 1'b0);
        check("R1 fault_pulse", bus_fault_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: matching bits, both values
        step(1, 1, 1, 0, "R8"); step(1, 1, 1, 0, "R8"); step(1, 1, 1, 1, "R8");
        step(1, 0, 0, 0, "R8"); step(1, 0, 0, 0, "R8"); step(1, 0, 0, 1, "R8");

        // R9: mismatch without strobe, and strobed mismatch when inactive
        step(1, 1, 0, 0, "R9"); step(1, 1, 0, 0, "R9"); step(1, 1, 0, 0, "R9");
        check("R9 no loss without strobe", arb_lost, 1'b0);
        step(0, 1, 0, 1, "R9");
        check("R9 no loss while inactive", arb_lost, 1'b0);

        // R10: SDA falls only one edge before strobe edge -> unseen
        step(1, 1, 1, 0, "R10"); step(1, 1, 1, 0, "R10"); step(1, 1, 1, 0, "R10");
        step(1, 1, 0, 0, "R10"); step(1, 1, 0, 1, "R10");
        check("R10 late SDA change not seen", arb_lost, 1'b0);
        step(1, 1, 0, 0, "R10");

        // R3/R4: now synchronized 0 with tx 1 -> loss
        step(1, 1, 0, 1, "R3");
        check("R3 loss flag set", arb_lost, 1'b1);
        check("R4 pulse in cycle after strobe", arb_lost_pulse, 1'b1);
        step(1, 1, 0, 0, "R4");
        check("R4 pulse single cycle", arb_lost_pulse, 1'b0);

        // R5: sticky, driver off even when sending 0, no more pulses
        step(1, 0, 0, 1, "R5");
        check("R5 pull_en off while lost", sda_pull_en, 1'b0);
        step(1, 1, 0, 1, "R5");
        check("R5 no second pulse", arb_lost_pulse, 1'b0);

        // R6: drop transfer clears flag
        step(0, 1, 1, 0, "R6");
        check("R6 cleared", arb_lost, 1'b0);
        step(0, 1, 1, 0, "R6"); step(0, 1, 1, 0, "R6");

        // R7: send 0, read 1 -> fault pulse, no loss
        step(1, 0, 1, 1, "R7");
        check("R7 fault pulse", bus_fault_pulse, 1'b1);
        check("R7 no loss", arb_lost, 1'b0);
        step(1, 0, 1, 0, "R7");
        check("R7 fault single cycle", bus_fault_pulse, 1'b0);

        // Random mix against the model
        for (int i = 0; i < N_RANDOM; i++) begin
            logic a, t, s, b;
            a = ($urandom % 8) != 0;
            t = $urandom % 2;
            s = ($urandom % 4) != 0;
            b = ($urandom % 3) == 0;
            step(a, t, s, b, "RND");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule